// File: doc/BRIEF.md
# Posted-Write Burst Splitter

This block sits on the write path from a PCI-style target port to a 64-bit system bus. The system bus accepts bursts of exactly one or two quad-words, each with every byte enabled. Incoming posted memory and I/O writes arrive as bursts of any length. Each beat is one quad-word with active-low byte enables. The beats pass through a two-entry write FIFO. A planner cuts them into the fewest legal system-bus transactions: two-quad-word bursts where alignment and enables allow, otherwise one-quad-word bursts. Partly enabled quad-words go out as single transfers, and fully disabled quad-words are dropped. Configuration-type writes are accepted at the input and discarded.

A static input selects a 32-bit target. In that mode every quad-word of a burst takes two data transfers, lower half first. The upper data lane is driven to zero and the upper four byte enables are held disabled. Partly enabled quad-words then go out as up to two 32-bit single transfers.

Every output beat waits on a ready handshake. Address, size code, data, enables and the last flag stay frozen until the handshake completes.

Top module: `pw_burst_splitter`

## Requirements
- R1: Output size codes are 3'b000 for a one-quad-word burst, 3'b001 for a two-quad-word burst, 3'b100 for a 64-bit single transfer and 3'b101 for a 32-bit single transfer. `out_last` is high on the final beat of each transaction.
- R2: A two-quad-word burst is issued only for two consecutive quad-words of the same input burst, both with `in_be_n` = 8'h00, where the first quad-word's address has bit 3 clear.
- R3: A fully enabled quad-word that cannot be paired under R2 goes out as a one-quad-word burst.
- R4: On a 64-bit target, a partly enabled quad-word goes out as one 64-bit single transfer at its own address, carrying its own data and byte enables.
- R5: A quad-word with `in_be_n` = 8'hFF produces no output transaction.
- R6: Every burst beat has all meaningful enables active: `out_be_n` = 8'h00 on a 64-bit target and 8'hF0 on a 32-bit target.
- R7: With `tgt_narrow` high, `out_data[63:32]` is zero and `out_be_n[7:4]` is 4'hF on every beat. Each quad-word of a burst takes two beats, lower half then upper half, and every beat carries the burst's start address.
- R8: With `tgt_narrow` high, a partly enabled quad-word goes out as a 32-bit single for each half with at least one enabled byte: at the quad-word address for the lower half and at that address plus 4 for the upper half. The half's data sits in `out_data[31:0]`. A half with all four enables off is skipped.
- R9: A beat with `in_cfg` high is always accepted (`in_ready` high) and never reaches the output.
- R10: While the FIFO holds two quad-words, a non-configuration beat sees `in_ready` low.
- R11: While `out_req` is high and `out_ready` is low, all output fields hold their values into the next cycle.
- R12: Quad-word k of an input burst has address `in_addr` with bits [2:0] cleared, plus 8·k. Output transactions appear in ascending address order.
- R13: After reset, `out_req` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tgt_narrow | input | 1 | High selects a 32-bit target; change only while idle |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted on this edge when high with in_valid |
| in_first | input | 1 | Beat opens a new burst; in_addr is sampled |
| in_last | input | 1 | Beat closes the burst |
| in_cfg | input | 1 | Configuration-type write, discarded |
| in_addr | input | 32 | Burst start byte address, bits [2:0] ignored |
| in_data | input | 64 | Quad-word write data |
| in_be_n | input | 8 | Active-low byte enables |
| out_req | output | 1 | Output beat request |
| out_ready | input | 1 | System bus takes the beat |
| out_addr | output | 32 | Transaction byte address |
| out_size | output | 3 | Transaction size code |
| out_data | output | 64 | Beat data |
| out_be_n | output | 8 | Beat active-low byte enables |
| out_last | output | 1 | Final beat of the transaction |

## Verification
Most internal faults reach the ports on the very first beat of the next transaction. A stale input address counter shows up as a wrong `out_addr`. A FIFO pointer that slips shows up as repeated or missing quad-word data inside a burst. A pairing decision taken too early shows up as a one-quad-word burst where a two-quad-word burst was due, which also changes the beat count. A wrong beat index in the sequencer shows up within the same transaction as swapped data halves, a misplaced `out_last` or a wrong 32-bit single address. The bench sweeps every enable pattern from a set of five, over burst lengths of one to three, at both alignments and both target widths. It drives a random-ish ready pattern and compares each handshaken beat with an arithmetic model.

// File: rtl/pwbs_pkg.sv
// Shared widths, size codes and the FIFO entry layout for the burst splitter.
package pwbs_pkg;
    localparam int unsigned PW_ADDR_W = 32;
    localparam int unsigned PW_DATA_W = 64;
    localparam int unsigned PW_BE_W   = PW_DATA_W / 8;

    // System-bus transaction size codes; the bus decodes these values.
    typedef enum logic [2:0] {
        SZ_ONE_QW   = 3'b000,
        SZ_TWO_QW   = 3'b001,
        SZ_SINGLE64 = 3'b100,
        SZ_SINGLE32 = 3'b101
    } pw_size_e;

    // One buffered quad-word with its resolved byte address.
    typedef struct packed {
        logic [PW_ADDR_W-1:0] addr;
        logic [PW_DATA_W-1:0] data;
        logic [PW_BE_W-1:0]   be_n;
        logic                 last;
    } pw_qw_t;
endpackage

// File: rtl/pw_in_stage.sv
// Input stage: resolves each beat's quad-word address from the burst start
// plus a running offset, drops configuration beats, and applies FIFO
// backpressure. Assumes in_first marks the opening beat of every burst.
module pw_in_stage
    import pwbs_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic                 in_first,
    input  logic                 in_last,
    input  logic                 in_cfg,
    input  logic [PW_ADDR_W-1:0] in_addr,
    input  logic [PW_DATA_W-1:0] in_data,
    input  logic [PW_BE_W-1:0]   in_be_n,
    input  logic                 fifo_full,
    output logic                 in_ready,
    output logic                 push,
    output pw_qw_t               push_qw
);
    localparam int unsigned OFS_W = $clog2(PW_BE_W);

    logic [PW_ADDR_W-1:0] next_addr;
    logic [PW_ADDR_W-1:0] beat_addr;

    // Configuration beats always drain; data beats wait for FIFO room.
    always_comb begin
        in_ready  = in_cfg | ~fifo_full;
        push      = in_valid & ~in_cfg & ~fifo_full;
        beat_addr = in_first ? {in_addr[PW_ADDR_W-1:OFS_W], {OFS_W{1'b0}}} : next_addr;
        push_qw.addr = beat_addr;
        push_qw.data = in_data;
        push_qw.be_n = in_be_n;
        push_qw.last = in_last;
    end

    // Running address of the next quad-word in the current burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_addr <= '0;
        end else if (push) begin
            next_addr <= beat_addr + PW_ADDR_W'(PW_BE_W);
        end
    end
endmodule

// File: rtl/pw_qw_fifo.sv
// Quad-word write FIFO with a two-entry look-ahead and a pop of one or two
// entries per cycle. Assumes DEPTH is a power of two and at least 2, and
// that the consumer never pops more entries than cnt reports.
module pw_qw_fifo
    import pwbs_pkg::*;
#(
    parameter int unsigned DEPTH = 2,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  pw_qw_t           wr_qw,
    input  logic [CNT_W-1:0] pop_n,
    output logic [CNT_W-1:0] cnt,
    output logic             full,
    output pw_qw_t           head0,
    output pw_qw_t           head1
);
    pw_qw_t             mem [DEPTH];
    logic [PTR_W-1:0]   wr_ptr;
    logic [PTR_W-1:0]   rd_ptr;
    logic [PTR_W-1:0]   rd_ptr_nx;

    // Entry storage, one write-enabled register per slot.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem[g] <= '0;
            end else if (push && wr_ptr == PTR_W'(g)) begin
                mem[g] <= wr_qw;
            end
        end
    end

    // Look-ahead ports and the full flag.
    always_comb begin
        rd_ptr_nx = PTR_W'(rd_ptr + 1'b1);
        head0     = mem[rd_ptr];
        head1     = mem[rd_ptr_nx];
        full      = (cnt == CNT_W'(DEPTH));
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push) wr_ptr <= PTR_W'(wr_ptr + 1'b1);
            rd_ptr <= PTR_W'(rd_ptr + PTR_W'(pop_n));
            cnt    <= cnt + CNT_W'(push) - pop_n;
        end
    end
endmodule

// File: rtl/pw_planner.sv
// Packet planner and beat sequencer. In idle it inspects the FIFO head:
// all-disabled quad-words are dropped, an aligned full quad-word waits for
// its partner unless it closes its burst, and otherwise one transaction is
// latched and its entries popped. While busy it steps a beat index on each
// ready handshake. Assumes tgt_narrow only changes while idle.
module pw_planner
    import pwbs_pkg::*;
#(
    parameter int unsigned CNT_W = 2,
    localparam int unsigned IDX_W = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tgt_narrow,
    input  logic [CNT_W-1:0]     cnt,
    input  pw_qw_t               head0,
    input  pw_qw_t               head1,
    input  logic                 out_ready,
    output logic [CNT_W-1:0]     pop_n,
    output logic                 busy,
    output pw_size_e             tx_size,
    output logic [PW_ADDR_W-1:0] tx_base,
    output logic [IDX_W-1:0]     cur,
    output logic [IDX_W-1:0]     last_idx,
    output logic [PW_DATA_W-1:0] tx_d0,
    output logic [PW_DATA_W-1:0] tx_d1,
    output logic [PW_BE_W-1:0]   tx_be0,
    output logic [PW_BE_W-1:0]   tx_be1
);
    localparam int unsigned PAIR_BIT = $clog2(2 * PW_BE_W) - 1;
    localparam int unsigned HBE      = PW_BE_W / 2;

    logic       h0_full, h0_none, have0, have1, pairable, hold_back;
    logic       do_drop, do_latch;
    pw_size_e   pick_size;
    logic [IDX_W-1:0] pick_start, pick_end;
    logic [CNT_W-1:0] pick_pop;

    // Decide what the head of the FIFO turns into.
    always_comb begin
        h0_full   = (head0.be_n == '0);
        h0_none   = &head0.be_n;
        have0     = (cnt != '0);
        have1     = (cnt >= CNT_W'(2));
        pairable  = h0_full & ~head0.addr[PAIR_BIT] & ~head0.last;
        hold_back = pairable & ~have1;
        do_drop   = ~busy & have0 & h0_none;
        do_latch  = ~busy & have0 & ~h0_none & ~hold_back;
        pick_start = '0;
        pick_end   = '0;
        pick_pop   = CNT_W'(1);
        pick_size  = SZ_ONE_QW;
        if (pairable && have1 && head1.be_n == '0) begin
            pick_size = SZ_TWO_QW;
            pick_pop  = CNT_W'(2);
            pick_end  = tgt_narrow ? IDX_W'(3) : IDX_W'(1);
        end else if (h0_full) begin
            pick_size = SZ_ONE_QW;
            pick_end  = tgt_narrow ? IDX_W'(1) : IDX_W'(0);
        end else if (!tgt_narrow) begin
            pick_size = SZ_SINGLE64;
        end else begin
            pick_size  = SZ_SINGLE32;
            pick_start = IDX_W'(&head0.be_n[HBE-1:0]);
            pick_end   = IDX_W'(~&head0.be_n[PW_BE_W-1:HBE]);
        end
        if (do_latch)     pop_n = pick_pop;
        else if (do_drop) pop_n = CNT_W'(1);
        else              pop_n = '0;
    end

    // Latch a transaction, then advance one beat per handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            cur      <= '0;
            last_idx <= '0;
            tx_size  <= SZ_ONE_QW;
            tx_base  <= '0;
            tx_d0    <= '0;
            tx_d1    <= '0;
            tx_be0   <= '0;
            tx_be1   <= '0;
        end else if (do_latch) begin
            busy     <= 1'b1;
            cur      <= pick_start;
            last_idx <= pick_end;
            tx_size  <= pick_size;
            tx_base  <= head0.addr;
            tx_d0    <= head0.data;
            tx_d1    <= head1.data;
            tx_be0   <= head0.be_n;
            tx_be1   <= head1.be_n;
        end else if (busy && out_ready) begin
            if (cur == last_idx) busy <= 1'b0;
            else                 cur  <= IDX_W'(cur + 1'b1);
        end
    end
endmodule

// File: rtl/pw_lane_fmt.sv
// Beat formatter: selects the quad-word and half for the current beat index
// and maps it onto the bus lanes. On a narrow target the upper lane is
// zeroed and its enables disabled; 32-bit singles offset the address by 4
// for the upper half.
module pw_lane_fmt
    import pwbs_pkg::*;
#(
    localparam int unsigned IDX_W = 2
) (
    input  logic                 tgt_narrow,
    input  pw_size_e             tx_size,
    input  logic [PW_ADDR_W-1:0] tx_base,
    input  logic [IDX_W-1:0]     cur,
    input  logic [IDX_W-1:0]     last_idx,
    input  logic [PW_DATA_W-1:0] tx_d0,
    input  logic [PW_DATA_W-1:0] tx_d1,
    input  logic [PW_BE_W-1:0]   tx_be0,
    input  logic [PW_BE_W-1:0]   tx_be1,
    output logic [PW_ADDR_W-1:0] out_addr,
    output logic [PW_DATA_W-1:0] out_data,
    output logic [PW_BE_W-1:0]   out_be_n,
    output logic                 out_last
);
    localparam int unsigned HDW = PW_DATA_W / 2;
    localparam int unsigned HBE = PW_BE_W / 2;

    logic                 qsel;
    logic                 upper;
    logic [PW_DATA_W-1:0] d;
    logic [PW_BE_W-1:0]   be;

    // Lane mapping for the current beat.
    always_comb begin
        qsel  = tgt_narrow ? cur[1] : cur[0];
        upper = cur[0];
        d     = qsel ? tx_d1 : tx_d0;
        be    = qsel ? tx_be1 : tx_be0;
        if (tgt_narrow) begin
            out_data = {{HDW{1'b0}}, upper ? d[PW_DATA_W-1:HDW] : d[HDW-1:0]};
            out_be_n = {{HBE{1'b1}}, upper ? be[PW_BE_W-1:HBE] : be[HBE-1:0]};
        end else begin
            out_data = d;
            out_be_n = be;
        end
        if (tx_size == SZ_SINGLE32) begin
            out_addr = tx_base + PW_ADDR_W'({upper, 2'b00});
            out_last = 1'b1;
        end else begin
            out_addr = tx_base;
            out_last = (cur == last_idx);
        end
    end
endmodule

// File: rtl/pw_burst_splitter.sv
// Top level of the posted-write burst splitter: input stage, write FIFO,
// packet planner and lane formatter in a chain. The output handshake is a
// plain request/ready pair; the request and all fields come from registers.
module pw_burst_splitter
    import pwbs_pkg::*;
#(
    parameter int unsigned FIFO_DEPTH = 2,
    localparam int unsigned CNT_W = $clog2(FIFO_DEPTH + 1),
    localparam int unsigned IDX_W = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tgt_narrow,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic                 in_first,
    input  logic                 in_last,
    input  logic                 in_cfg,
    input  logic [PW_ADDR_W-1:0] in_addr,
    input  logic [PW_DATA_W-1:0] in_data,
    input  logic [PW_BE_W-1:0]   in_be_n,
    output logic                 out_req,
    input  logic                 out_ready,
    output logic [PW_ADDR_W-1:0] out_addr,
    output logic [2:0]           out_size,
    output logic [PW_DATA_W-1:0] out_data,
    output logic [PW_BE_W-1:0]   out_be_n,
    output logic                 out_last
);
    logic             push, fifo_full;
    pw_qw_t           push_qw, head0, head1;
    logic [CNT_W-1:0] fifo_cnt, pop_n;
    pw_size_e         tx_size;
    logic [PW_ADDR_W-1:0] tx_base;
    logic [IDX_W-1:0] cur, last_idx;
    logic [PW_DATA_W-1:0] tx_d0, tx_d1;
    logic [PW_BE_W-1:0]   tx_be0, tx_be1;

    pw_in_stage u_in (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
        .in_last(in_last), .in_cfg(in_cfg), .in_addr(in_addr), .in_data(in_data),
        .in_be_n(in_be_n), .fifo_full(fifo_full), .in_ready(in_ready),
        .push(push), .push_qw(push_qw)
    );

    pw_qw_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .wr_qw(push_qw), .pop_n(pop_n),
        .cnt(fifo_cnt), .full(fifo_full), .head0(head0), .head1(head1)
    );

    pw_planner #(.CNT_W(CNT_W)) u_plan (
        .clk(clk), .rst_n(rst_n), .tgt_narrow(tgt_narrow), .cnt(fifo_cnt),
        .head0(head0), .head1(head1), .out_ready(out_ready), .pop_n(pop_n),
        .busy(out_req), .tx_size(tx_size), .tx_base(tx_base), .cur(cur),
        .last_idx(last_idx), .tx_d0(tx_d0), .tx_d1(tx_d1), .tx_be0(tx_be0),
        .tx_be1(tx_be1)
    );

    pw_lane_fmt u_fmt (
        .tgt_narrow(tgt_narrow), .tx_size(tx_size), .tx_base(tx_base), .cur(cur),
        .last_idx(last_idx), .tx_d0(tx_d0), .tx_d1(tx_d1), .tx_be0(tx_be0),
        .tx_be1(tx_be1), .out_addr(out_addr), .out_data(out_data),
        .out_be_n(out_be_n), .out_last(out_last)
    );

    assign out_size = tx_size;
endmodule

// File: rtl/pw_burst_splitter_chk.sv
// Property checker for the burst splitter, attached by bind below.
module pw_burst_splitter_chk #(
    parameter int unsigned AW    = 32,
    parameter int unsigned DEPTH = 2,
    parameter int unsigned CNT_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tgt_narrow,
    input logic             in_valid,
    input logic             in_cfg,
    input logic             in_ready,
    input logic [CNT_W-1:0] fifo_cnt,
    input logic             out_req,
    input logic             out_ready,
    input logic [AW-1:0]    out_addr,
    input logic [2:0]       out_size,
    input logic [63:0]      out_data,
    input logic [7:0]       out_be_n,
    input logic             out_last
);
    assert_size_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_req |-> (out_size == 3'b000 || out_size == 3'b001 ||
                     out_size == 3'b100 || out_size == 3'b101));

    assert_pair_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_req && out_size == 3'b001) |-> !out_addr[3]);

    assert_single_partial_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_req && out_size == 3'b100) |-> (out_be_n != 8'h00 && out_be_n != 8'hFF));

    assert_burst_enables_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_req && !out_size[2]) |-> (out_be_n == (tgt_narrow ? 8'hF0 : 8'h00)));

    assert_narrow_lanes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_req && tgt_narrow) |-> (out_data[63:32] == 32'h0 && out_be_n[7:4] == 4'hF));

    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_cfg && fifo_cnt == CNT_W'(DEPTH)) |-> !in_ready);

    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_req && !out_ready) |=> (out_req && $stable(out_addr) && $stable(out_size) &&
                                     $stable(out_data) && $stable(out_be_n) && $stable(out_last)));
endmodule

bind pw_burst_splitter pw_burst_splitter_chk #(
    .AW(pwbs_pkg::PW_ADDR_W), .DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .tgt_narrow(tgt_narrow), .in_valid(in_valid),
    .in_cfg(in_cfg), .in_ready(in_ready), .fifo_cnt(fifo_cnt), .out_req(out_req),
    .out_ready(out_ready), .out_addr(out_addr), .out_size(out_size),
    .out_data(out_data), .out_be_n(out_be_n), .out_last(out_last)
);

// File: tb/pw_burst_splitter_bench.sv
`timescale 1ns/1ps
module pw_burst_splitter_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        tgt_narrow, in_valid, in_ready, in_first, in_last, in_cfg;
    logic [31:0] in_addr;
    logic [63:0] in_data;
    logic [7:0]  in_be_n;
    logic        out_req, out_ready, out_last;
    logic [31:0] out_addr;
    logic [2:0]  out_size;
    logic [63:0] out_data;
    logic [7:0]  out_be_n;

    int checks = 0;
    int fails  = 0;
    bit stall  = 1'b0;
    logic [7:0] lfsr = 8'h5B;

    // Expected beats of the current case.
    logic [31:0] e_addr [64];
    logic [2:0]  e_size [64];
    logic [63:0] e_data [64];
    logic [7:0]  e_be   [64];
    logic        e_last [64];
    int e_n = 0;
    int g_n = 0;
    logic [7:0]  c_be [8];
    logic [63:0] c_d  [8];

    // Hold tracking for R11.
    bit          h_pend = 1'b0;
    logic [31:0] h_addr;
    logic [2:0]  h_size;
    logic [63:0] h_data;
    logic [7:0]  h_be;
    logic        h_last;

    always #2.5 clk = ~clk;

    pw_burst_splitter u_pw_burst_splitter (
        .clk(clk), .rst_n(rst_n), .tgt_narrow(tgt_narrow), .in_valid(in_valid),
        .in_ready(in_ready), .in_first(in_first), .in_last(in_last), .in_cfg(in_cfg),
        .in_addr(in_addr), .in_data(in_data), .in_be_n(in_be_n), .out_req(out_req),
        .out_ready(out_ready), .out_addr(out_addr), .out_size(out_size),
        .out_data(out_data), .out_be_n(out_be_n), .out_last(out_last)
    );

    function automatic string tag_of(logic [2:0] sz, logic nar);
        case (sz)
            3'b001:  return nar ? "R1 R2 R6 R7 R12" : "R1 R2 R6 R12";
            3'b000:  return nar ? "R1 R3 R6 R7 R12" : "R1 R3 R6 R12";
            3'b100:  return "R1 R4";
            default: return "R1 R8";
        endcase
    endfunction

    task automatic push_exp(logic [31:0] a, logic [2:0] sz, logic [63:0] d, logic [7:0] b, logic l);
        e_addr[e_n] = a; e_size[e_n] = sz; e_data[e_n] = d; e_be[e_n] = b; e_last[e_n] = l;
        e_n++;
    endtask

    task automatic push_burst(logic [31:0] a, logic [2:0] sz, int i0, int nq, bit nar);
        for (int k = 0; k < nq; k++) begin
            if (nar) begin
                push_exp(a, sz, {32'h0, c_d[i0+k][31:0]}, 8'hF0, 1'b0);
                push_exp(a, sz, {32'h0, c_d[i0+k][63:32]}, 8'hF0, k == nq - 1);
            end else begin
                push_exp(a, sz, c_d[i0+k], 8'h00, k == nq - 1);
            end
        end
    endtask

    // Arithmetic model of the splitting rules over c_be/c_d.
    task automatic build_exp(int n, logic [31:0] a0, bit nar);
        int i = 0;
        logic [31:0] a;
        e_n = 0;
        g_n = 0;
        while (i < n) begin
            a = {a0[31:3], 3'b000} + 32'(8 * i);
            if (c_be[i] == 8'hFF) begin
                i++;
            end else if (c_be[i] != 8'h00) begin
                if (!nar) begin
                    push_exp(a, 3'b100, c_d[i], c_be[i], 1'b1);
                end else begin
                    if (c_be[i][3:0] != 4'hF) push_exp(a, 3'b101, {32'h0, c_d[i][31:0]}, {4'hF, c_be[i][3:0]}, 1'b1);
                    if (c_be[i][7:4] != 4'hF) push_exp(a + 32'd4, 3'b101, {32'h0, c_d[i][63:32]}, {4'hF, c_be[i][7:4]}, 1'b1);
                end
                i++;
            end else if (!a[3] && i + 1 < n && c_be[i+1] == 8'h00) begin
                push_burst(a, 3'b001, i, 2, nar);
                i += 2;
            end else begin
                push_burst(a, 3'b000, i, 1, nar);
                i++;
            end
        end
    endtask

    task automatic check(bit ok, string msg);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s", msg);
        end
    endtask

    // Ready pattern and output monitor, sampled just before the rising edge.
    always @(negedge clk) begin
        out_ready = stall ? 1'b0 : (lfsr[0] | lfsr[1]);
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        #2;
        if (rst_n === 1'b1) begin
            if (h_pend)
                check(out_req && out_addr == h_addr && out_size == h_size && out_data == h_data &&
                      out_be_n == h_be && out_last == h_last,
                      $sformatf("R11 hold: got %h/%b/%h/%h/%b exp %h/%b/%h/%h/%b", out_addr, out_size,
                                out_data, out_be_n, out_last, h_addr, h_size, h_data, h_be, h_last));
            h_pend = out_req && !out_ready;
            h_addr = out_addr; h_size = out_size; h_data = out_data; h_be = out_be_n; h_last = out_last;
            if (out_req && out_ready) begin
                if (g_n >= e_n) begin
                    check(1'b0, $sformatf("R5 R9 extra beat: got addr=%h size=%b exp none", out_addr, out_size));
                end else begin
                    check(out_addr == e_addr[g_n] && out_size == e_size[g_n] && out_data == e_data[g_n] &&
                          out_be_n == e_be[g_n] && out_last == e_last[g_n],
                          $sformatf("%s beat %0d: got %h/%b/%h/%h/%b exp %h/%b/%h/%h/%b",
                                    tag_of(e_size[g_n], tgt_narrow), g_n, out_addr, out_size, out_data,
                                    out_be_n, out_last, e_addr[g_n], e_size[g_n], e_data[g_n],
                                    e_be[g_n], e_last[g_n]));
                end
                g_n++;
            end
        end
    end

    task automatic send_beat(bit f, bit l, bit cfg, logic [31:0] a, logic [63:0] d, logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1; in_first = f; in_last = l; in_cfg = cfg;
        in_addr = a; in_data = d; in_be_n = b;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
    endtask

    task automatic idle_in();
        @(negedge clk);
        in_valid = 1'b0; in_cfg = 1'b0; in_first = 1'b0; in_last = 1'b0;
    endtask

    task automatic finish_case(int n);
        while (g_n < e_n) @(negedge clk);
        repeat (6) @(negedge clk);
        check(g_n == e_n, $sformatf("R5 R9 beat count (len %0d): got %0d exp %0d", n, g_n, e_n));
    endtask

    // One case: optional configuration burst, then the data burst.
    task automatic run_case(int n, logic [31:0] a_in, bit nar, bit with_cfg);
        @(negedge clk);
        tgt_narrow = nar;
        build_exp(n, a_in, nar);
        if (with_cfg) begin
            send_beat(1'b1, 1'b0, 1'b1, a_in ^ 32'h40, ~c_d[0], 8'h00);
            send_beat(1'b0, 1'b1, 1'b1, a_in ^ 32'h40, c_d[0], 8'h00);
        end
        for (int k = 0; k < n; k++)
            send_beat(k == 0, k == n - 1, 1'b0, a_in, c_d[k], c_be[k]);
        idle_in();
        finish_case(n);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired: got hang exp completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] pat [5];
        int cid = 0;
        pat[0] = 8'h00; pat[1] = 8'hFF; pat[2] = 8'hF0; pat[3] = 8'h0F; pat[4] = 8'h3C;
        rst_n = 1'b0; tgt_narrow = 1'b0; in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
        in_cfg = 1'b0; in_addr = '0; in_data = '0; in_be_n = '0;
        repeat (3) @(negedge clk);
        #1;
        check(!out_req && in_ready, $sformatf("R13 in reset: got req=%b rdy=%b exp 0/1", out_req, in_ready));
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        check(!out_req && in_ready, $sformatf("R13 after reset: got req=%b rdy=%b exp 0/1", out_req, in_ready));

        // Backpressure: stall the output, fill the FIFO, probe in_ready.
        stall = 1'b1;
        for (int k = 0; k < 5; k++) begin
            c_be[k] = 8'h00;
            c_d[k]  = 64'hC0DE_0000_0000_0000 + 64'(k);
        end
        build_exp(5, 32'h2000_0000, 1'b0);
        for (int k = 0; k < 4; k++)
            send_beat(k == 0, 1'b0, 1'b0, 32'h2000_0000, c_d[k], 8'h00);
        @(negedge clk);
        in_valid = 1'b1; in_first = 1'b0; in_last = 1'b1; in_cfg = 1'b0;
        in_data = c_d[4]; in_be_n = 8'h00;
        #1;
        check(!in_ready, $sformatf("R10 full FIFO: got in_ready=%b exp 0", in_ready));
        in_cfg = 1'b1;
        #1;
        check(in_ready, $sformatf("R9 cfg when full: got in_ready=%b exp 1", in_ready));
        in_cfg = 1'b0;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        stall = 1'b0;
        send_beat(1'b0, 1'b1, 1'b0, 32'h2000_0000, c_d[4], 8'h00);
        idle_in();
        finish_case(5);

        // Exhaustive enable patterns over short bursts, both widths and alignments.
        for (int nar = 0; nar < 2; nar++) begin
            for (int al = 0; al < 2; al++) begin
                for (int n = 1; n <= 3; n++) begin
                    int lim = (n == 1) ? 5 : (n == 2) ? 25 : 125;
                    for (int code = 0; code < lim; code++) begin
                        int c = code;
                        for (int k = 0; k < n; k++) begin
                            c_be[k] = pat[c % 5];
                            c = c / 5;
                            c_d[k] = 64'(cid) * 64'h9E37_79B9_7F4A_7C15 + 64'(k * 3 + 1);
                        end
                        run_case(n, 32'h1000_0000 + 32'(cid * 64) + 32'(al * 8) + 32'(cid % 8),
                                 nar[0], (cid % 5) == 0);
                        cid++;
                    end
                end
                // Longer fully enabled bursts, and one with a hole.
                for (int n = 4; n <= 7; n++) begin
                    for (int k = 0; k < n; k++) begin
                        c_be[k] = (n == 7 && k == 3) ? 8'hFF : 8'h00;
                        c_d[k]  = 64'(cid) * 64'h0123_4567_89AB_CDEF + 64'(k);
                    end
                    run_case(n, 32'h3000_0000 + 32'(cid * 64) + 32'(al * 8), nar[0], 1'b0);
                    cid++;
                end
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule